// File: doc/BRIEF.md
# DMA Channel Ring Control Register

This block is the control and status register for one DMA channel that walks a ring of descriptors in memory. Software writes one 64-bit word to set the ring's base address, its length in descriptors and a weight value, to start or stop the channel, to abort it, and to rewind the descriptor pointer to the start of the ring. The same word, read back, shows the configuration, the channel state, whether a descriptor is in use, and two sticky status flags: descriptor interrupt and transfer error.

The engine reports three kinds of event: a descriptor is busy, a descriptor has completed (optionally with its interrupt flag), and a transfer error occurred. The block turns these into a channel enable, a one-cycle abort request, a 16-byte-aligned current descriptor address that steps around the ring, and a single interrupt line. A primary read address clears the sticky flags as a side effect. A second, read-only address returns the same word without clearing anything, so a debugger can look at the status without disturbing it.

Top module: `dma_ring_ctrl`

## Requirements
- R1: After reset, chan_en, abort_req, irq and cur_dscr are all zero, and a read of the primary address returns zero.
- R2: A write to the primary address stores the ring base (bits 39:4), ring size (bits 55:40) and weight (bits 58:56). A read returns them at the same positions, with bits 3:0 and bit 62 always zero. Read data appears with bus_rvalid one cycle after the read strobe.
- R3: Writing bit 63 as 1 (with bit 62 as 0) raises chan_en in the cycle after the write. Bit 63 reads back the current chan_en.
- R4: Writing bit 63 as 0 while dscr_busy is high keeps chan_en high until dscr_busy is sampled low, and chan_en drops in the cycle after that. With dscr_busy low, chan_en drops in the cycle after the write.
- R5: Writing bit 62 as 1 drops chan_en in the cycle after the write and pulses abort_req high for one cycle. This happens even if bit 63 is also written as 1.
- R6: A pulse on xfer_err sets the error flag (read at bit 61), drops chan_en, pulses abort_req and raises irq, all in the next cycle.
- R7: dscr_done together with dscr_irq sets the interrupt flag (read at bit 60) and raises irq in the next cycle. dscr_done without dscr_irq leaves the flag and irq unchanged.
- R8: A read of the primary address returns the flags as they were and then clears them. A read of the debug address returns the same word and clears nothing. A new set event in the same cycle as a clearing read leaves the flag set.
- R9: Each dscr_done advances cur_dscr by 16 bytes. After ring_size completions it returns to the base address, and a ring_size of 0 means 65536 descriptors.
- R10: Writing bit 61 as 1 loads cur_dscr with the base written in that word (bits 39:4, low nibble zero) and restarts the ring count. It does not change the error flag.
- R11: Bit 59 of the read word reflects dscr_busy at the time of the read strobe.
- R12: A write to the debug address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | BUS_AW | Register byte offset (primary 0x00, debug 0x18) |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| dscr_busy | input | 1 | Engine is working on a descriptor of this channel |
| dscr_done | input | 1 | One-cycle pulse: a descriptor completed |
| dscr_irq | input | 1 | The completing descriptor asked for an interrupt (qualifies dscr_done) |
| xfer_err | input | 1 | One-cycle pulse: a data transfer error |
| chan_en | output | 1 | Channel enabled |
| abort_req | output | 1 | One-cycle request to stop the engine at once |
| cur_dscr | output | ADDR_W | Current descriptor byte address |
| irq | output | 1 | Interrupt: OR of the interrupt and error flags |

## Verification
Every result is registered once. A write, a completion or an error shows up at the outputs in the cycle after the edge that samples it. Read data and bus_rvalid arrive one cycle after the read strobe, and the word holds the flag values from before any clear. The bench drives inputs on the falling edge and samples outputs on the next falling edge, half a cycle after the edge that updates them. A read task queues the expected word when it raises the strobe, and a monitor pops the queue on each bus_rvalid. The drain case is checked both on the falling edge where dscr_busy drops, when chan_en must still be high, and one cycle later, when it must be low.

// File: rtl/dma_ring_pkg.sv
// Package: shared types for the DMA ring control register.
// Assumes a single clock domain and one channel per instance.
package dma_ring_pkg;

    // Channel enable states
    typedef enum logic [1:0] {
        EN_IDLE  = 2'd0,
        EN_RUN   = 2'd1,
        EN_DRAIN = 2'd2
    } en_state_e;

    // Decoded register commands for one cycle
    typedef struct packed {
        logic cfg_wr;   // write to the primary address
        logic start;    // enable requested, no abort
        logic stop;     // enable cleared, no abort
        logic abort;    // abort requested
        logic rewind;   // pointer rewind requested
        logic rd_clr;   // read of the primary address
        logic rd_map;   // read of any mapped address
    } bus_cmd_t;

endpackage

// File: rtl/drc_decode.sv
// Module: drc_decode
// Decodes the register bus into one-cycle commands. Purely combinational.
// Assumes bus_wr and bus_rd are never high in the same cycle.
module drc_decode
    import dma_ring_pkg::*;
#(
    parameter int          BUS_AW    = 5,
    parameter logic [BUS_AW-1:0] PRIM_ADDR = '0,
    parameter logic [BUS_AW-1:0] DBG_ADDR  = '1
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              wd_en,
    input  logic              wd_abort,
    input  logic              wd_rewind,
    output bus_cmd_t          cmd
);

    logic hit_prim;
    logic hit_dbg;

    // Address match for the two mapped offsets
    always_comb begin
        hit_prim = (bus_addr == PRIM_ADDR);
        hit_dbg  = (bus_addr == DBG_ADDR);
    end

    // Command build; abort overrides enable in the same word
    always_comb begin
        cmd        = '0;
        cmd.cfg_wr = bus_wr & hit_prim;
        cmd.abort  = cmd.cfg_wr & wd_abort;
        cmd.start  = cmd.cfg_wr & wd_en & ~wd_abort;
        cmd.stop   = cmd.cfg_wr & ~wd_en & ~wd_abort;
        cmd.rewind = cmd.cfg_wr & wd_rewind;
        cmd.rd_clr = bus_rd & hit_prim;
        cmd.rd_map = bus_rd & (hit_prim | hit_dbg);
    end

endmodule

// File: rtl/drc_status.sv
// Module: drc_status
// Holds the sticky status flags. Each flag sets on its event and clears
// on a clearing read. A set in the same cycle as a clear wins.
module drc_status #(
    parameter int NFLAG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] set_i,
    input  logic             clr_i,
    output logic [NFLAG-1:0] flag_o
);

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        logic flag_q;

        // Sticky flag update with set priority
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else
                flag_q <= set_i[g] | (flag_q & ~clr_i);
        end

        assign flag_o[g] = flag_q;
    end

endmodule

// File: rtl/drc_ptr.sv
// Module: drc_ptr
// Current descriptor pointer. It steps one descriptor per completion and
// wraps to the ring base after size completions (size 0 means 2**SIZE_W).
// A rewind loads the newly written base and wins over a completion.
module drc_ptr #(
    parameter int PTR_W  = 36,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rewind_i,
    input  logic [PTR_W-1:0]  new_base_i,
    input  logic [PTR_W-1:0]  base_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              adv_i,
    output logic [PTR_W-1:0]  ptr_o
);

    logic [PTR_W-1:0]  ptr_q;
    logic [SIZE_W-1:0] idx_q;
    logic [SIZE_W-1:0] last_idx;
    logic              at_last;

    // Index of the final descriptor; size 0 wraps to all ones
    always_comb begin
        last_idx = size_i - SIZE_W'(1);
        at_last  = (idx_q == last_idx);
    end

    // Pointer and ring index update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            idx_q <= '0;
        end else if (rewind_i) begin
            ptr_q <= new_base_i;
            idx_q <= '0;
        end else if (adv_i) begin
            if (at_last) begin
                ptr_q <= base_i;
                idx_q <= '0;
            end else begin
                ptr_q <= ptr_q + PTR_W'(1);
                idx_q <= idx_q + SIZE_W'(1);
            end
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/drc_enable.sv
// Module: drc_enable
// Channel enable state machine. A stop while a descriptor is busy drains
// until busy drops. An abort or a transfer error disables the channel at
// once and raises a one-cycle abort request.
module drc_enable
    import dma_ring_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic abort_i,
    input  logic err_i,
    input  logic busy_i,
    output logic chan_en_o,
    output logic abort_req_o
);

    en_state_e state_q;
    en_state_e state_d;
    logic      abort_q;

    // Next-state selection, kill first
    always_comb begin
        state_d = state_q;
        if (abort_i || err_i)
            state_d = EN_IDLE;
        else if (start_i)
            state_d = EN_RUN;
        else if (stop_i)
            state_d = (state_q != EN_IDLE && busy_i) ? EN_DRAIN : EN_IDLE;
        else if (state_q == EN_DRAIN && !busy_i)
            state_d = EN_IDLE;
    end

    // State and abort pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EN_IDLE;
            abort_q <= 1'b0;
        end else begin
            state_q <= state_d;
            abort_q <= abort_i | err_i;
        end
    end

    assign chan_en_o   = (state_q != EN_IDLE);
    assign abort_req_o = abort_q;

endmodule

// File: rtl/dma_ring_ctrl.sv
// Module: dma_ring_ctrl
// Control and status register for one DMA descriptor ring: configuration,
// enable control, sticky status, pointer walk and a side-effect-free debug
// read alias. Read data is registered and valid one cycle after the strobe.
// Assumes a read and a write never happen in the same cycle.
module dma_ring_ctrl
    import dma_ring_pkg::*;
#(
    parameter int ADDR_W   = 40,
    parameter int SIZE_W   = 16,
    parameter int WEIGHT_W = 3,
    parameter int ALIGN_W  = 4,
    parameter int BUS_AW   = 5,
    parameter logic [BUS_AW-1:0] PRIM_ADDR = 5'h00,
    parameter logic [BUS_AW-1:0] DBG_ADDR  = 5'h18,
    localparam int REG_W   = ADDR_W + SIZE_W + WEIGHT_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_rvalid,
    input  logic              dscr_busy,
    input  logic              dscr_done,
    input  logic              dscr_irq,
    input  logic              xfer_err,
    output logic              chan_en,
    output logic              abort_req,
    output logic [ADDR_W-1:0] cur_dscr,
    output logic              irq
);

    localparam int PTR_W   = ADDR_W - ALIGN_W;
    localparam int SIZE_LO = ADDR_W;
    localparam int WGT_LO  = ADDR_W + SIZE_W;
    localparam int ACT_BIT = WGT_LO + WEIGHT_W;
    localparam int IRQ_BIT = ACT_BIT + 1;
    localparam int ERR_BIT = ACT_BIT + 2;
    localparam int ABT_BIT = ACT_BIT + 3;
    localparam int EN_BIT  = ACT_BIT + 4;

    bus_cmd_t            cmd;
    logic [PTR_W-1:0]    base_q;
    logic [SIZE_W-1:0]   size_q;
    logic [WEIGHT_W-1:0] weight_q;
    logic [1:0]          flags;
    logic [1:0]          flag_set;
    logic [PTR_W-1:0]    ptr;
    logic [REG_W-1:0]    rd_word;
    logic [REG_W-1:0]    rdata_q;
    logic                rvalid_q;

    drc_decode #(
        .BUS_AW    (BUS_AW),
        .PRIM_ADDR (PRIM_ADDR),
        .DBG_ADDR  (DBG_ADDR)
    ) u_dec (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .wd_en     (bus_wdata[EN_BIT]),
        .wd_abort  (bus_wdata[ABT_BIT]),
        .wd_rewind (bus_wdata[ERR_BIT]),
        .cmd       (cmd)
    );

    // Configuration fields, loaded on every primary write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            size_q   <= '0;
            weight_q <= '0;
        end else if (cmd.cfg_wr) begin
            base_q   <= bus_wdata[ADDR_W-1:ALIGN_W];
            size_q   <= bus_wdata[SIZE_LO +: SIZE_W];
            weight_q <= bus_wdata[WGT_LO +: WEIGHT_W];
        end
    end

    // Flag set events: bit 0 interrupt, bit 1 error
    always_comb begin
        flag_set[0] = dscr_done & dscr_irq;
        flag_set[1] = xfer_err;
    end

    drc_status #(
        .NFLAG (2)
    ) u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (cmd.rd_clr),
        .flag_o (flags)
    );

    drc_ptr #(
        .PTR_W  (PTR_W),
        .SIZE_W (SIZE_W)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rewind_i   (cmd.rewind),
        .new_base_i (bus_wdata[ADDR_W-1:ALIGN_W]),
        .base_i     (base_q),
        .size_i     (size_q),
        .adv_i      (dscr_done),
        .ptr_o      (ptr)
    );

    drc_enable u_en (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (cmd.start),
        .stop_i      (cmd.stop),
        .abort_i     (cmd.abort),
        .err_i       (xfer_err),
        .busy_i      (dscr_busy),
        .chan_en_o   (chan_en),
        .abort_req_o (abort_req)
    );

    // Read word assembly from live state
    always_comb begin
        rd_word                         = '0;
        rd_word[ADDR_W-1:ALIGN_W]       = base_q;
        rd_word[SIZE_LO +: SIZE_W]      = size_q;
        rd_word[WGT_LO +: WEIGHT_W]     = weight_q;
        rd_word[ACT_BIT]                = dscr_busy;
        rd_word[IRQ_BIT]                = flags[0];
        rd_word[ERR_BIT]                = flags[1];
        rd_word[EN_BIT]                 = chan_en;
    end

    // Registered read return, pre-clear values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd)
                rdata_q <= cmd.rd_map ? rd_word : '0;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign cur_dscr   = {ptr, {ALIGN_W{1'b0}}};
    assign irq        = |flags;

endmodule

// File: rtl/dma_ring_ctrl_chk.sv
// Module: dma_ring_ctrl_chk
// Port-level assertions for dma_ring_ctrl, attached with bind.
module dma_ring_ctrl_chk #(
    parameter int ADDR_W  = 40,
    parameter int ALIGN_W = 4,
    parameter int BUS_AW  = 5,
    parameter int REG_W   = 64,
    parameter logic [BUS_AW-1:0] PRIM_ADDR = 5'h00,
    parameter logic [BUS_AW-1:0] DBG_ADDR  = 5'h18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              dscr_busy,
    input logic              dscr_done,
    input logic              dscr_irq,
    input logic              xfer_err,
    input logic              chan_en,
    input logic              abort_req,
    input logic [ADDR_W-1:0] cur_dscr,
    input logic              irq
);

    localparam int EN_BIT  = REG_W - 1;
    localparam int ABT_BIT = REG_W - 2;
    localparam int REW_BIT = REG_W - 3;

    logic prim_wr;
    assign prim_wr = bus_wr && (bus_addr == PRIM_ADDR);

    a_r3_enable_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_wr && bus_wdata[EN_BIT] && !bus_wdata[ABT_BIT] && !xfer_err) |=> chan_en);

    a_r4_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && dscr_busy && !xfer_err && !(prim_wr && bus_wdata[ABT_BIT])) |=> chan_en);

    a_r5_abort_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_wr && bus_wdata[ABT_BIT]) |=> (!chan_en && abort_req));

    a_r6_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> (!chan_en && abort_req && irq));

    a_r7_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (dscr_done && dscr_irq) |=> irq);

    a_r8_debug_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DBG_ADDR && irq) |=> irq);

    a_r10_rewind_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (prim_wr && bus_wdata[REW_BIT]) |=>
        (cur_dscr == {$past(bus_wdata[ADDR_W-1:ALIGN_W]), {ALIGN_W{1'b0}}}));

endmodule

bind dma_ring_ctrl dma_ring_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .ALIGN_W   (ALIGN_W),
    .BUS_AW    (BUS_AW),
    .REG_W     (REG_W),
    .PRIM_ADDR (PRIM_ADDR),
    .DBG_ADDR  (DBG_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .dscr_busy (dscr_busy),
    .dscr_done (dscr_done),
    .dscr_irq  (dscr_irq),
    .xfer_err  (xfer_err),
    .chan_en   (chan_en),
    .abort_req (abort_req),
    .cur_dscr  (cur_dscr),
    .irq       (irq)
);

// File: tb/dma_ring_ctrl_test.sv
// Bench for dma_ring_ctrl: scoreboard on register reads, direct checks on
// the control outputs. Inputs change on the falling edge; outputs are
// sampled on the following falling edge.
module dma_ring_ctrl_test;

    localparam logic [4:0] PRIM = 5'h00;
    localparam logic [4:0] DBG  = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_rvalid;
    logic        dscr_busy = 1'b0;
    logic        dscr_done = 1'b0;
    logic        dscr_irq = 1'b0;
    logic        xfer_err = 1'b0;
    logic        chan_en;
    logic        abort_req;
    logic [39:0] cur_dscr;
    logic        irq;

    int          errs = 0;
    int          checks = 0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    dma_ring_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .dscr_busy(dscr_busy), .dscr_done(dscr_done),
        .dscr_irq(dscr_irq), .xfer_err(xfer_err), .chan_en(chan_en),
        .abort_req(abort_req), .cur_dscr(cur_dscr), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mkw(bit en, bit ab, bit rew, logic [2:0] w,
                                        logic [15:0] s, logic [35:0] b, logic [3:0] lo);
        return {en, ab, rew, 1'b0, 1'b0, w, s, b, lo};
    endfunction

    function automatic logic [63:0] mkr(bit en, bit err, bit iq, bit busy, logic [2:0] w,
                                        logic [15:0] s, logic [35:0] b);
        return {en, 1'b0, err, iq, busy, w, s, b, 4'h0};
    endfunction

    function automatic logic [63:0] addr64(logic [35:0] b);
        return {24'h0, b, 4'h0};
    endfunction

    task automatic wr(logic [4:0] a, logic [63:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, logic [63:0] exp, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic done_pulse(bit f);
        @(negedge clk);
        dscr_done = 1'b1; dscr_irq = f;
        @(negedge clk);
        dscr_done = 1'b0; dscr_irq = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    // Monitor: pop expected read words as data returns
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("R2 unexpected rvalid", 64'h1, 64'h0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, bus_rdata, e);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    localparam logic [35:0] B1 = 36'h0_0ABC_DE01;
    localparam logic [35:0] B2 = 36'h0_4000_0000;
    localparam logic [35:0] B3 = 36'h0_0000_7770;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 chan_en", {63'h0, chan_en}, 64'h0);
        chk("R1 abort_req", {63'h0, abort_req}, 64'h0);
        chk("R1 irq", {63'h0, irq}, 64'h0);
        chk("R1 cur_dscr", {24'h0, cur_dscr}, 64'h0);
        rd(PRIM, 64'h0, "R1 reset readback");

        // R10 rewind load, R2 field readback with low nibble ignored
        wr(PRIM, mkw(0, 0, 1, 3'd5, 16'd3, B1, 4'hF));
        chk("R10 rewind to base", {24'h0, cur_dscr}, addr64(B1));
        chk("R3 still disabled", {63'h0, chan_en}, 64'h0);
        rd(PRIM, mkr(0, 0, 0, 0, 3'd5, 16'd3, B1), "R2 field readback");

        // R12 debug writes ignored
        wr(DBG, mkw(1, 0, 1, 3'd2, 16'd9, B2, 4'h0));
        chk("R12 no enable", {63'h0, chan_en}, 64'h0);
        chk("R12 no rewind", {24'h0, cur_dscr}, addr64(B1));
        rd(PRIM, mkr(0, 0, 0, 0, 3'd5, 16'd3, B1), "R12 config unchanged");

        // R3 enable
        wr(PRIM, mkw(1, 0, 0, 3'd5, 16'd3, B1, 4'h0));
        chk("R3 chan_en up", {63'h0, chan_en}, 64'h1);
        rd(DBG, mkr(1, 0, 0, 0, 3'd5, 16'd3, B1), "R3 enable readback");

        // R9 advance and wrap on a three-entry ring; R7 no flag without dscr_irq
        done_pulse(0);
        chk("R9 step 1", {24'h0, cur_dscr}, addr64(B1 + 36'd1));
        chk("R7 no irq without flag", {63'h0, irq}, 64'h0);
        done_pulse(0);
        chk("R9 step 2", {24'h0, cur_dscr}, addr64(B1 + 36'd2));
        done_pulse(0);
        chk("R9 wrap to base", {24'h0, cur_dscr}, addr64(B1));

        // R7 interrupt flag
        done_pulse(1);
        chk("R7 irq high", {63'h0, irq}, 64'h1);
        chk("R9 step after wrap", {24'h0, cur_dscr}, addr64(B1 + 36'd1));

        // R8 debug read keeps, primary read clears
        rd(DBG, mkr(1, 0, 1, 0, 3'd5, 16'd3, B1), "R8 debug shows irq flag");
        chk("R8 debug read keeps irq", {63'h0, irq}, 64'h1);
        rd(PRIM, mkr(1, 0, 1, 0, 3'd5, 16'd3, B1), "R8 primary shows irq flag");
        chk("R8 primary read clears irq", {63'h0, irq}, 64'h0);

        // R8 set in the same cycle as a clearing read
        @(negedge clk);
        bus_addr = PRIM; bus_rd = 1'b1; dscr_done = 1'b1; dscr_irq = 1'b1;
        exp_q.push_back(mkr(1, 0, 0, 0, 3'd5, 16'd3, B1));
        tag_q.push_back("R8 coincident read word");
        @(negedge clk);
        bus_rd = 1'b0; dscr_done = 1'b0; dscr_irq = 1'b0;
        chk("R8 set beats clear", {63'h0, irq}, 64'h1);
        rd(PRIM, mkr(1, 0, 1, 0, 3'd5, 16'd3, B1), "R8 flag after coincidence");
        chk("R8 cleared again", {63'h0, irq}, 64'h0);

        // R11 busy bit, R4 drain
        @(negedge clk);
        dscr_busy = 1'b1;
        rd(PRIM, mkr(1, 0, 0, 1, 3'd5, 16'd3, B1), "R11 busy bit");
        wr(PRIM, mkw(0, 0, 0, 3'd5, 16'd3, B1, 4'h0));
        chk("R4 held while busy", {63'h0, chan_en}, 64'h1);
        repeat (3) @(negedge clk);
        chk("R4 still held", {63'h0, chan_en}, 64'h1);
        dscr_busy = 1'b0;
        chk("R4 held at busy drop", {63'h0, chan_en}, 64'h1);
        @(negedge clk);
        chk("R4 off after drain", {63'h0, chan_en}, 64'h0);
        wr(PRIM, mkw(1, 0, 0, 3'd5, 16'd3, B1, 4'h0));
        wr(PRIM, mkw(0, 0, 0, 3'd5, 16'd3, B1, 4'h0));
        chk("R4 off at once when idle", {63'h0, chan_en}, 64'h0);

        // R5 abort overrides enable
        wr(PRIM, mkw(1, 0, 0, 3'd5, 16'd3, B1, 4'h0));
        chk("R5 pre-enabled", {63'h0, chan_en}, 64'h1);
        wr(PRIM, mkw(1, 1, 0, 3'd5, 16'd3, B1, 4'h0));
        chk("R5 chan_en down", {63'h0, chan_en}, 64'h0);
        chk("R5 abort_req pulse", {63'h0, abort_req}, 64'h1);
        @(negedge clk);
        chk("R5 abort_req one cycle", {63'h0, abort_req}, 64'h0);

        // R6 transfer error
        wr(PRIM, mkw(1, 0, 0, 3'd5, 16'd3, B1, 4'h0));
        @(negedge clk);
        dscr_busy = 1'b1; xfer_err = 1'b1;
        @(negedge clk);
        xfer_err = 1'b0; dscr_busy = 1'b0;
        chk("R6 chan_en down", {63'h0, chan_en}, 64'h0);
        chk("R6 abort_req", {63'h0, abort_req}, 64'h1);
        chk("R6 irq", {63'h0, irq}, 64'h1);

        // R10 rewind keeps error flag; size 0 ring
        wr(PRIM, mkw(0, 0, 1, 3'd1, 16'd0, B2, 4'h0));
        chk("R10 rewind new base", {24'h0, cur_dscr}, addr64(B2));
        chk("R10 error kept", {63'h0, irq}, 64'h1);
        rd(DBG, mkr(0, 1, 0, 0, 3'd1, 16'd0, B2), "R6 error flag debug");
        rd(PRIM, mkr(0, 1, 0, 0, 3'd1, 16'd0, B2), "R6 error flag primary");
        chk("R8 error cleared", {63'h0, irq}, 64'h0);

        // R9 ring size 0 means 65536 entries
        @(negedge clk);
        dscr_done = 1'b1;
        repeat (65535) @(negedge clk);
        dscr_done = 1'b0;
        chk("R9 last of 65536", {24'h0, cur_dscr}, addr64(B2 + 36'd65535));
        done_pulse(0);
        chk("R9 wrap after 65536", {24'h0, cur_dscr}, addr64(B2));

        // R10 rewind mid-ring
        done_pulse(0);
        wr(PRIM, mkw(0, 0, 1, 3'd1, 16'd2, B3, 4'h0));
        chk("R10 mid-ring rewind", {24'h0, cur_dscr}, addr64(B3));
        done_pulse(0);
        done_pulse(0);
        chk("R9 count restarted by rewind", {24'h0, cur_dscr}, addr64(B3));

        repeat (3) @(negedge clk);
        chk("R2 all reads returned", {32'h0, 32'(exp_q.size())}, 64'h0);
        summary();
    end

endmodule